// File: doc/BRIEF.md
# Circular Trace Capture Buffer

The block is an on-chip sink for trace data. It takes 32-bit words from a valid/ready stream and stores them in an internal circular RAM. Software sets it up and reads it out through a small register port with one-cycle read latency. That port gives access to:
- the two word pointers,
- a read-data window and a write-data window, each of which advances its pointer on every access,
- a RAM-full flag,
- the RAM depth,
- the capture and formatter controls.

Capture ends in one of three ways. Software clears the enable bit. A programmed number of words arrives after a trigger pulse. A manual flush completes while stop-on-flush is armed. In every case the buffer first pads the write pointer to the next 4-word frame boundary with a fixed fill word, and only then reports the formatter as stopped. This leaves the stored trace made of whole frames that a decoder can walk.

A typical session follows four steps:
1. Clear the pointers.
2. Program the trigger count and the stop conditions.
3. Set the enable bit and let the trace source stream.
4. After the stopped status appears, read the RAM back through the data window. If the full flag is set, start the read at the write pointer; otherwise start it at zero.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the following hold:
  - the depth register (0x004) reads DEPTH with bit 31 at 0;
  - status (0x00C), control (0x020) and both pointers (read 0x014, write 0x018) read 0;
  - formatter status (0x300) reads 2, meaning bit 1 (stopped) is set;
  - trc_ready is low.
- R2: A register read issued in one cycle gives reg_rvalid high and the data on reg_rdata in the next cycle.
- R3: Each read of the read-data window (0x010) returns the RAM word at the read pointer and advances the read pointer by one. The pointer wraps from DEPTH-1 to 0.
- R4: A write to the write-data window (0x024) has one of two outcomes:
  - if control bit 0 is 0 and the formatter is stopped, it stores reg_wdata at the write pointer and advances the write pointer;
  - otherwise it is ignored and the write pointer does not move.
- R5: Writing the read or write pointer register loads it directly. Status bit 0 (full) sets when the write pointer wraps from DEPTH-1 to 0. Writing 0 to the write pointer clears the full flag; writing any other value leaves it as it was.
- R6: Writing 1 to control bit 0 clears the stopped bit and raises trc_ready. Each accepted trace word is stored at the write pointer, and the write pointer then advances.
- R7: Writing 0 to control bit 0 while capturing drops trc_ready at once. The block then writes PAD_WORD until the write pointer is a multiple of 4, and only then sets formatter status bit 1.
- R8: When formatter control bit 13 is set, a trc_trig pulse during capture arms a stop. After the number of further accepted words held in the trigger count register (0x01C), input is refused. The block then pads to the frame boundary and sets the stopped bit.
- R9: When formatter control bit 13 is clear, trc_trig has no effect and capture continues.
- R10: Writing 1 to formatter control bit 6 starts a manual flush. During the flush:
  - bit 6 reads 1 and trc_ready is low;
  - the block pads to the frame boundary, then clears bit 6 by itself.
  
  If bit 12 is clear, capture resumes after the flush.
- R11: When formatter control bit 12 is set, completion of a manual flush sets the stopped bit, and capture does not resume.
- R12: Formatter control bits 0, 12 and 13 read back as written. All its other bits, apart from bit 6, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| trc_valid | input | 1 | Trace word offered |
| trc_data | input | 32 | Trace word |
| trc_ready | output | 1 | Trace word accepted when high together with trc_valid |
| trc_trig | input | 1 | Trigger pulse from the trace source |

## Verification
The block is exercised with several input patterns, each chosen to tell two behaviours apart:
- **Unaligned stream ended by disable.** A stream of six words followed by a disable shows that padding fills exactly the missing frame slots.
- **Already-aligned stop.** A trigger count that lands exactly on a frame boundary stops with no pad word at all, while a count that ends mid-frame is padded.
- **Trigger with the stop bit clear.** Sending a trigger pulse with the stop bit clear tells an ignored trigger apart from an armed one.
- **Capture across the last RAM slot.** A capture that crosses the last slot separates a correct wrap, with the full flag set, from a linear overrun.
- **Full-flag clearing.** Loading a nonzero pointer and then zero shows which load clears the flag.
- **Flush with and without stop-on-flush.** Running a manual flush both ways distinguishes resuming capture from a final stop.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam logic [11:0] OFS_DEPTH  = 12'h004;
  localparam logic [11:0] OFS_STAT   = 12'h00C;
  localparam logic [11:0] OFS_RDWIN  = 12'h010;
  localparam logic [11:0] OFS_RPTR   = 12'h014;
  localparam logic [11:0] OFS_WPTR   = 12'h018;
  localparam logic [11:0] OFS_TRGCNT = 12'h01C;
  localparam logic [11:0] OFS_CTL    = 12'h020;
  localparam logic [11:0] OFS_WRWIN  = 12'h024;
  localparam logic [11:0] OFS_FSTAT  = 12'h300;
  localparam logic [11:0] OFS_FCTL   = 12'h304;

  localparam int FC_FMT_EN   = 0;
  localparam int FC_FLUSH    = 6;
  localparam int FC_STOP_FL  = 12;
  localparam int FC_STOP_TRG = 13;
  localparam int FS_STOPPED  = 1;
endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // one write port, one registered read port: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcb_ptr.sv
module tcb_ptr #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr,
  output logic          wrap
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // a load wins over an increment in the same cycle
  assign wrap = inc && !load && (ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tcb_ctrl.sv
module tcb_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_bit,
  input  logic             flush_set,
  input  logic             stop_on_trg,
  input  logic             stop_on_fl,
  input  logic [CNT_W-1:0] trg_count,
  input  logic             trig_in,
  input  logic             accept,
  input  logic             aligned,
  output logic             ctl_en,
  output logic             stopped,
  output logic             flush_busy,
  output logic             ready,
  output logic             pad_we
);
  logic             stop_pend;
  logic             trg_armed;
  logic [CNT_W-1:0] remain;
  logic             trg_spent;
  logic             hold;
  logic             stop_done;
  logic             flush_done;

  assign trg_spent  = trg_armed && (remain == '0);
  assign hold       = stop_pend || flush_busy || trg_spent;
  // R6 R8 R10: input taken only while enabled, running and nothing pending
  assign ready      = ctl_en && !stopped && !hold;
  // R7: fill words until the write pointer sits on a frame boundary
  assign pad_we     = !stopped && (stop_pend || flush_busy) && !aligned;
  assign stop_done  = stop_pend && aligned;
  assign flush_done = flush_busy && (stopped || aligned);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en     <= 1'b0;
      stopped    <= 1'b1;
      stop_pend  <= 1'b0;
      flush_busy <= 1'b0;
      trg_armed  <= 1'b0;
      remain     <= '0;
    end else begin
      // R8: count words after the trigger, then request a stop
      if (trg_spent) begin
        trg_armed <= 1'b0;
        stop_pend <= 1'b1;
      end else if (trg_armed && accept) begin
        remain <= remain - 1'b1;
      end
      // R9: trigger only arms when the stop-on-trigger bit is set
      if (trig_in && stop_on_trg && ready && !trg_armed) begin
        trg_armed <= 1'b1;
        remain    <= trg_count;
      end
      if (stop_done) begin
        stop_pend <= 1'b0;
        stopped   <= 1'b1;
      end
      // R10 R11
      if (flush_done) begin
        flush_busy <= 1'b0;
        if (stop_on_fl) begin
          stopped   <= 1'b1;
          stop_pend <= 1'b0;
        end
      end
      if (flush_set) flush_busy <= 1'b1;
      if (ctl_wr) begin
        ctl_en <= ctl_bit;
        if (ctl_bit && !ctl_en) begin
          stopped   <= 1'b0;
          stop_pend <= 1'b0;
          trg_armed <= 1'b0;
        end else if (!ctl_bit && ctl_en && !stopped) begin
          stop_pend <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int          DEPTH       = 256,
  parameter int          FRAME_WORDS = 4,
  parameter int          CNT_W       = 16,
  parameter logic [31:0] PAD_WORD    = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_rvalid,
  input  logic        trc_valid,
  input  logic [31:0] trc_data,
  output logic        trc_ready,
  input  logic        trc_trig
);
  localparam int AW = $clog2(DEPTH);
  localparam int FB = $clog2(FRAME_WORDS);

  logic [AW-1:0]    rptr, wptr;
  logic             rp_wrap, wp_wrap;
  logic             rp_load, wp_load, rp_inc;
  logic             ctl_en, stopped, flush_busy, pad_we;
  logic             accept, sw_wr, ram_we, aligned;
  logic [31:0]      ram_wd, ram_q;
  logic             full;
  logic             fc_en, fc_stop_fl, fc_stop_trg;
  logic [CNT_W-1:0] trg_q;
  logic             fctl_wr, ctl_wr;
  logic [31:0]      rd_mux, rdata_q;
  logic             sel_ram_q;

  assign fctl_wr = reg_wr && (reg_addr == OFS_FCTL);
  assign ctl_wr  = reg_wr && (reg_addr == OFS_CTL);
  assign rp_load = reg_wr && (reg_addr == OFS_RPTR);
  assign wp_load = reg_wr && (reg_addr == OFS_WPTR);
  assign rp_inc  = reg_rd && (reg_addr == OFS_RDWIN);
  // R4: software fill only while disabled and stopped
  assign sw_wr   = reg_wr && (reg_addr == OFS_WRWIN) && !ctl_en && stopped;
  assign accept  = trc_valid && trc_ready;
  assign aligned = (wptr[FB-1:0] == '0);

  always_comb begin
    ram_we = accept || pad_we || sw_wr;
    if (accept)      ram_wd = trc_data;
    else if (pad_we) ram_wd = PAD_WORD;
    else             ram_wd = reg_wdata;
  end

  tcb_ram #(.DEPTH(DEPTH), .DW(32)) u_ram (
    .clk(clk), .we(ram_we), .waddr(wptr), .wdata(ram_wd),
    .raddr(rptr), .rdata(ram_q)
  );

  tcb_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst(rst), .load(wp_load), .load_val(reg_wdata[AW-1:0]),
    .inc(ram_we), .ptr(wptr), .wrap(wp_wrap)
  );

  tcb_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst(rst), .load(rp_load), .load_val(reg_wdata[AW-1:0]),
    .inc(rp_inc), .ptr(rptr), .wrap(rp_wrap)
  );

  tcb_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .ctl_wr(ctl_wr), .ctl_bit(reg_wdata[0]),
    .flush_set(fctl_wr && reg_wdata[FC_FLUSH]),
    .stop_on_trg(fc_stop_trg), .stop_on_fl(fc_stop_fl),
    .trg_count(trg_q), .trig_in(trc_trig),
    .accept(accept), .aligned(aligned),
    .ctl_en(ctl_en), .stopped(stopped), .flush_busy(flush_busy),
    .ready(trc_ready), .pad_we(pad_we)
  );

  // R5: full flag and R12: formatter control bits
  always_ff @(posedge clk) begin
    if (rst) begin
      full        <= 1'b0;
      fc_en       <= 1'b0;
      fc_stop_fl  <= 1'b0;
      fc_stop_trg <= 1'b0;
      trg_q       <= '0;
    end else begin
      if (wp_load && (reg_wdata == 32'h0)) full <= 1'b0;
      else if (wp_wrap)                     full <= 1'b1;
      if (fctl_wr) begin
        fc_en       <= reg_wdata[FC_FMT_EN];
        fc_stop_fl  <= reg_wdata[FC_STOP_FL];
        fc_stop_trg <= reg_wdata[FC_STOP_TRG];
      end
      if (reg_wr && (reg_addr == OFS_TRGCNT)) trg_q <= reg_wdata[CNT_W-1:0];
    end
  end

  // R1 R2: register readback
  always_comb begin
    rd_mux = 32'h0;
    unique case (reg_addr)
      OFS_DEPTH:  rd_mux = 32'(DEPTH) & 32'h7FFF_FFFF;
      OFS_STAT:   rd_mux[0] = full;
      OFS_RPTR:   rd_mux[AW-1:0] = rptr;
      OFS_WPTR:   rd_mux[AW-1:0] = wptr;
      OFS_TRGCNT: rd_mux[CNT_W-1:0] = trg_q;
      OFS_CTL:    rd_mux[0] = ctl_en;
      OFS_FSTAT:  rd_mux[FS_STOPPED] = stopped;
      OFS_FCTL: begin
        rd_mux[FC_FMT_EN]   = fc_en;
        rd_mux[FC_FLUSH]    = flush_busy;
        rd_mux[FC_STOP_FL]  = fc_stop_fl;
        rd_mux[FC_STOP_TRG] = fc_stop_trg;
      end
      default:    rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      rdata_q    <= 32'h0;
      sel_ram_q  <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      sel_ram_q  <= rp_inc;
      if (reg_rd) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata = sel_ram_q ? ram_q : rdata_q;

  logic unused_ok;
  assign unused_ok = rp_wrap;
endmodule

// File: rtl/tcb_chk.sv
module tcb_chk #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int FB    = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_rd,
  input logic          reg_rvalid,
  input logic          accept,
  input logic          wp_load,
  input logic [AW-1:0] wptr,
  input logic          stopped,
  input logic          flush_busy,
  input logic          full
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);

  // R7
  stop_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stopped) |-> (wptr[FB-1:0] == '0));

  // R10
  flush_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(flush_busy) && !stopped) |-> (wptr[FB-1:0] == '0));

  // R5
  full_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> (wptr == '0));

  // R6
  store_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !wp_load) |=>
      (wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + 1'b1)));
endmodule

bind trace_capture_buf tcb_chk #(.DEPTH(DEPTH), .AW(AW), .FB(FB)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid),
  .accept(accept), .wp_load(wp_load), .wptr(wptr), .stopped(stopped),
  .flush_busy(flush_busy), .full(full)
);

// File: tb/trace_capture_buf_bench.sv
module trace_capture_buf_bench;
  import tcb_pkg::*;

  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        trc_valid = 1'b0;
  logic [31:0] trc_data = '0;
  logic        trc_ready;
  logic        trc_trig = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH)) u_trace_capture_buf (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .trc_valid(trc_valid), .trc_data(trc_data),
    .trc_ready(trc_ready), .trc_trig(trc_trig)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rvalid ? reg_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic push(input logic [31:0] d);
    logic r;
    @(negedge clk);
    trc_valid = 1'b1; trc_data = d;
    r = 1'b0;
    while (!r) begin
      #1 r = trc_ready;
      @(negedge clk);
    end
    trc_valid = 1'b0;
  endtask

  task automatic feed(input logic [31:0] base, output int n);
    logic r;
    int idle;
    n = 0; idle = 0;
    @(negedge clk);
    trc_valid = 1'b1; trc_data = base;
    while (idle < 8 && n < 64) begin
      #1 r = trc_ready;
      @(negedge clk);
      if (r) begin n++; trc_data = base + n; idle = 0; end
      else idle++;
    end
    trc_valid = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trc_trig = 1'b1;
    @(negedge clk);
    trc_trig = 1'b0;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    rd(OFS_DEPTH, d);
    check("R1 depth", d, 32'(DEPTH));
    check("R2 rvalid/data", d[31], 1'b0);
    rd_chk("R1 status", OFS_STAT, 32'h0);
    rd_chk("R1 ctl", OFS_CTL, 32'h0);
    rd_chk("R1 fstat", OFS_FSTAT, 32'h2);
    rd_chk("R1 wptr", OFS_WPTR, 32'h0);
    rd_chk("R1 rptr", OFS_RPTR, 32'h0);
    check("R1 ready", {31'b0, trc_ready}, 32'h0);
  endtask

  task automatic test_windows();
    wr(OFS_WPTR, 16);
    for (int i = 0; i < 3; i++) wr(OFS_WRWIN, 32'h5500_0000 + i);
    rd_chk("R4 wptr after fill", OFS_WPTR, 19);
    wr(OFS_RPTR, 16);
    for (int i = 0; i < 3; i++) rd_chk("R3 window data", OFS_RDWIN, 32'h5500_0000 + i);
    rd_chk("R3 rptr advance", OFS_RPTR, 19);
    wr(OFS_FCTL, 32'h1);
    wr(OFS_CTL, 1);
    wr(OFS_WRWIN, 32'h1234_5678);
    rd_chk("R4 ignored while enabled", OFS_WPTR, 19);
    wr(OFS_CTL, 0);
    repeat (4) @(negedge clk);
    rd_chk("R7 padded wptr", OFS_WPTR, 20);
    rd_chk("R7 stopped", OFS_FSTAT, 32'h2);
    wr(OFS_RPTR, 19);
    rd_chk("R7 pad word", OFS_RDWIN, 32'h0);
  endtask

  task automatic test_capture();
    wr(OFS_WPTR, 0);
    wr(OFS_CTL, 1);
    check("R6 ready on enable", {31'b0, trc_ready}, 32'h1);
    rd_chk("R6 running", OFS_FSTAT, 32'h0);
    for (int i = 0; i < 6; i++) push(32'hA000_0000 + i);
    rd_chk("R6 wptr", OFS_WPTR, 6);
    wr(OFS_CTL, 0);
    check("R7 ready drop", {31'b0, trc_ready}, 32'h0);
    repeat (4) @(negedge clk);
    rd_chk("R7 wptr aligned", OFS_WPTR, 8);
    rd_chk("R7 stopped", OFS_FSTAT, 32'h2);
    wr(OFS_RPTR, 0);
    for (int i = 0; i < 6; i++) rd_chk("R6 stored word", OFS_RDWIN, 32'hA000_0000 + i);
    for (int i = 0; i < 2; i++) rd_chk("R7 pad fill", OFS_RDWIN, 32'h0);
  endtask

  task automatic test_wrap();
    wr(OFS_WPTR, DEPTH - 4);
    wr(OFS_CTL, 1);
    for (int i = 0; i < 8; i++) push(32'hB000_0000 + i);
    wr(OFS_CTL, 0);
    repeat (3) @(negedge clk);
    rd_chk("R5 wptr wrapped", OFS_WPTR, 4);
    rd_chk("R5 full set", OFS_STAT, 32'h1);
    wr(OFS_RPTR, DEPTH - 4);
    for (int i = 0; i < 8; i++) rd_chk("R3 wrap read", OFS_RDWIN, 32'hB000_0000 + i);
    rd_chk("R3 rptr wrapped", OFS_RPTR, 4);
    wr(OFS_WPTR, 4);
    rd_chk("R5 nonzero load keeps full", OFS_STAT, 32'h1);
    wr(OFS_WPTR, 0);
    rd_chk("R5 zero load clears full", OFS_STAT, 32'h0);
  endtask

  task automatic test_trigger();
    int n;
    wr(OFS_WPTR, 0);
    wr(OFS_TRGCNT, 5);
    wr(OFS_FCTL, 32'h2001);
    wr(OFS_CTL, 1);
    for (int i = 0; i < 3; i++) push(32'hC000_0000 + i);
    pulse_trig();
    feed(32'hC100_0000, n);
    check("R8 words after trigger", n, 5);
    rd_chk("R8 wptr", OFS_WPTR, 8);
    rd_chk("R8 stopped", OFS_FSTAT, 32'h2);
    wr(OFS_CTL, 0);
    wr(OFS_WPTR, 0);
    wr(OFS_TRGCNT, 2);
    wr(OFS_CTL, 1);
    push(32'hC200_0000);
    pulse_trig();
    feed(32'hC300_0000, n);
    check("R8 short count", n, 2);
    rd_chk("R8 padded to frame", OFS_WPTR, 4);
    rd_chk("R8 stopped again", OFS_FSTAT, 32'h2);
    wr(OFS_RPTR, 3);
    rd_chk("R8 pad word", OFS_RDWIN, 32'h0);
    wr(OFS_CTL, 0);
    wr(OFS_WPTR, 0);
    wr(OFS_TRGCNT, 0);
    wr(OFS_FCTL, 32'h1);
    wr(OFS_CTL, 1);
    pulse_trig();
    for (int i = 0; i < 4; i++) push(32'hC400_0000 + i);
    repeat (2) @(negedge clk);
    check("R9 trigger ignored", {31'b0, trc_ready}, 32'h1);
    rd_chk("R9 still running", OFS_FSTAT, 32'h0);
    wr(OFS_CTL, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic test_flush();
    wr(OFS_WPTR, 0);
    wr(OFS_FCTL, 32'h1);
    wr(OFS_CTL, 1);
    push(32'hD000_0000);
    push(32'hD000_0001);
    wr(OFS_FCTL, 32'h41);
    rd_chk("R10 flush busy", OFS_FCTL, 32'h41);
    repeat (6) @(negedge clk);
    rd_chk("R10 flush self-clears", OFS_FCTL, 32'h1);
    rd_chk("R10 padded", OFS_WPTR, 4);
    check("R10 capture resumes", {31'b0, trc_ready}, 32'h1);
    push(32'hD000_0002);
    wr(OFS_FCTL, 32'h1041);
    repeat (8) @(negedge clk);
    rd_chk("R11 padded", OFS_WPTR, 8);
    rd_chk("R11 stopped", OFS_FSTAT, 32'h2);
    check("R11 ready low", {31'b0, trc_ready}, 32'h0);
    wr(OFS_CTL, 0);
  endtask

  task automatic test_fctl_bits();
    wr(OFS_FCTL, 32'h0000_3001);
    rd_chk("R12 readback", OFS_FCTL, 32'h0000_3001);
    wr(OFS_FCTL, 32'hFFFF_CFBE);
    rd_chk("R12 reserved zero", OFS_FCTL, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    test_reset();
    test_windows();
    test_capture();
    test_wrap();
    test_trigger();
    test_flush();
    test_fctl_bits();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule